// File: doc/BRIEF.md
# High-Speed Root Port Status and Control Register

This block keeps the 32-bit status and control word of one root port in a high-speed USB host. Software reads the word combinationally and writes it with a single-cycle strobe. Port events arrive as input pins: device presence, overcurrent, port error, resume detection and the end of a bus reset. They update read-only status fields and set sticky change flags. Software clears a change flag by writing a 1 to it.

The block also drives a port sequencer through level outputs for bus reset, suspend and resume signalling. A validated one-hot select goes to the electrical test logic, and a low-speed hint is raised when the line state shows a low-speed device before enabling. Port ownership follows an external configured flag. Removing port power, whether by software or by an overcurrent onset when a power switch exists, zeroes every power-dependent field in the same cycle.

Top module: `hs_port_csr`

## Requirements
- R1: After reset, with no device present and the configured flag low, the word reads 0x00003000: power on (bit 12), owner set (bit 13), all else 0.
- R2: Connect status (bit 0) shows the presence input one cycle later. Connect change (bit 1) is set on every change of presence, even when it is already set. Writing 1 to bit 1 clears it.
- R3: Overcurrent active (bit 4) shows the overcurrent input one cycle later. Overcurrent change (bit 5) is set on each change of that input. Writing 1 to bit 5 clears it.
- R4: Writing 1 to enable (bit 2) has no effect, and writing 0 disables the port. Only a reset completion with a high-speed device attached sets bit 2. A port error while enabled clears bit 2 and sets enable change (bit 3), and writing 1 to bit 3 clears it.
- R5: Writing 1 to port reset (bit 8) sets it and raises `port_reset_o`. Writing 0 does not clear it. Only `rst_done` clears it.
- R6: Writing 1 to suspend (bit 7) takes effect only while the port is enabled. Suspend never reads 1 while bit 2 is 0.
- R7: Force resume (bit 6) is set by a software write of 1, or by `resume_det` while suspended. Writing 0 clears it, and that falling edge also clears suspend.
- R8: Owner (bit 13) is held at 1 while the configured flag is low. It goes to 0 one cycle after that flag rises. Otherwise it is writable.
- R9: With a power switch present, port power (bit 12) is writable and is cleared by the onset of overcurrent.
- R10: While bit 12 is 0, bits 22:20, 15:14, 8, 7, 6, 3, 2, 1 and 0 read 0, and line status (bits 11:10) reads 0.
- R11: Test control (bits 19:16) accepts codes 0 to 5 and ignores writes of codes 6 to 15. `test_sel_o` bit k-1 is high only for code k.
- R12: Line status shows `line_state` (bit 11 = D+, bit 10 = D-). `lowspeed_o` is high when powered, connected, not enabled and the line state is 01.
- R13: Bits 31:23 and bit 9 always read 0 and ignore writes.
- R14: A hardware set of a change flag in the same cycle as a software clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register word |
| cfg_flag | input | 1 | Configured flag from the controller |
| dev_connected | input | 1 | Device presence on the port |
| oc_active | input | 1 | Overcurrent condition present |
| line_state | input | 2 | D+ (bit 1) and D- (bit 0) levels |
| port_error | input | 1 | Port error pulse from the sequencer |
| resume_det | input | 1 | J-to-K resume detected pulse |
| rst_done | input | 1 | Bus reset completed pulse |
| hs_detected | input | 1 | Device found high-speed during reset |
| port_reset_o | output | 1 | Bus reset request to the sequencer |
| suspend_o | output | 1 | Suspend request to the sequencer |
| resume_o | output | 1 | Resume signalling request to the sequencer |
| test_sel_o | output | 5 | One-hot electrical test mode select |
| lowspeed_o | output | 1 | Low-speed device hint |

## Verification
Every state field is registered once. An event pin or a write strobe applied before a rising edge therefore shows in `rd_data` and in the sequencer outputs right after that edge, which is a one-cycle latency. Line status and the low-speed hint are combinational from `line_state` and appear in the same cycle. The bench drives inputs shortly after a rising edge and samples one time unit after the following edge. Each expected value is thus taken one edge after its stimulus, never at the edge itself.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned TEST_W       = 4;
  localparam int unsigned N_TEST_MODES = 5;
  localparam int unsigned WAKE_W       = 3;
  localparam int unsigned IND_W        = 2;
  localparam int unsigned N_FLAGS      = 3;

  // field positions (software-visible layout)
  localparam int unsigned B_CCS  = 0;
  localparam int unsigned B_CSC  = 1;
  localparam int unsigned B_ENA  = 2;
  localparam int unsigned B_ENC  = 3;
  localparam int unsigned B_OCA  = 4;
  localparam int unsigned B_OCC  = 5;
  localparam int unsigned B_FPR  = 6;
  localparam int unsigned B_SUS  = 7;
  localparam int unsigned B_RST  = 8;
  localparam int unsigned B_LS   = 10;
  localparam int unsigned B_PWR  = 12;
  localparam int unsigned B_OWN  = 13;
  localparam int unsigned B_IND  = 14;
  localparam int unsigned B_TEST = 16;
  localparam int unsigned B_WAKE = 20;

  localparam logic [WORD_W-1:0] RESET_WORD     = 32'h0000_3000;
  localparam logic [WORD_W-1:0] PWR_GATED_MASK = 32'h0070_C1CF;
  localparam logic [WORD_W-1:0] RSVD_MASK      = 32'hFF80_0200;

  // index of each sticky change flag in the flag bank
  typedef enum logic [1:0] {
    FLG_CONN = 2'd0,
    FLG_ENA  = 2'd1,
    FLG_OVC  = 2'd2
  } flag_e;
endpackage

// File: rtl/hs_port_evflag.sv
// Sticky change flag: hardware set wins over a write-one clear;
// keep_i low forces the flag to zero.
module hs_port_evflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic keep_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_nxt;

  always_comb begin
    flag_nxt = keep_i & (set_i | (flag_q & ~clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/hs_port_owner.sv
// Ownership bit: forced to 1 while unconfigured, cleared on the
// configured flag's rising edge, otherwise software-writable.
module hs_port_owner (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_flag,
  input  logic wr_en,
  input  logic wr_bit,
  output logic own_o
);
  logic own_q;
  logic own_nxt;
  logic cfg_q;
  logic cfg_rise;

  always_comb begin
    cfg_rise = cfg_flag & ~cfg_q;
    own_nxt  = own_q;
    if (wr_en) begin
      own_nxt = wr_bit;
    end
    if (cfg_rise) begin
      own_nxt = 1'b0;
    end
    if (!cfg_flag) begin
      own_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= 1'b1;
      cfg_q <= 1'b0;
    end else begin
      own_q <= own_nxt;
      cfg_q <= cfg_flag;
    end
  end

  assign own_o = own_q;
endmodule

// File: rtl/hs_port_testsel.sv
// Test-mode code holder: only codes up to N_MODES are accepted;
// one-hot decode of the active code.
module hs_port_testsel #(
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned N_MODES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic [CODE_W-1:0] code_o,
  output logic [N_MODES-1:0] sel_o
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(N_MODES);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_nxt;
  logic              code_en;

  always_comb begin
    code_en  = wr_en & (wr_code <= MAX_CODE);
    code_nxt = code_en ? wr_code : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else begin
      code_q <= code_nxt;
    end
  end

  for (genvar i = 0; i < N_MODES; i++) begin : g_dec
    assign sel_o[i] = (code_q == CODE_W'(i + 1));
  end

  assign code_o = code_q;
endmodule

// File: rtl/hs_port_csr.sv
module hs_port_csr
  import hs_port_pkg::*;
#(
  parameter bit HAS_PWR_SWITCH = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [WORD_W-1:0]       wr_data,
  output logic [WORD_W-1:0]       rd_data,
  input  logic                    cfg_flag,
  input  logic                    dev_connected,
  input  logic                    oc_active,
  input  logic [1:0]              line_state,
  input  logic                    port_error,
  input  logic                    resume_det,
  input  logic                    rst_done,
  input  logic                    hs_detected,
  output logic                    port_reset_o,
  output logic                    suspend_o,
  output logic                    resume_o,
  output logic [N_TEST_MODES-1:0] test_sel_o,
  output logic                    lowspeed_o
);
  // power
  logic pp_q;
  logic pp_nxt;
  // status state
  logic ccs_q, ccs_nxt;
  logic oca_q;
  logic pr_q, pr_nxt, pr_rise;
  logic ped_q, ped_nxt;
  logic sus_q, sus_nxt;
  logic fpr_q, fpr_nxt, fpr_fall;
  logic [WAKE_W-1:0] wake_q, wake_nxt;
  logic [IND_W-1:0]  ind_q, ind_nxt;
  logic oc_rise, oc_chg, disc;
  // flags
  logic [N_FLAGS-1:0] flag_set, flag_clr, flag_keep, flag_q;
  logic own;
  logic [TEST_W-1:0] test_code;

  // ---------------- port power variant ----------------
  if (HAS_PWR_SWITCH) begin : g_pwr_sw
    always_comb begin
      pp_nxt = pp_q;
      if (wr_en) begin
        pp_nxt = wr_data[B_PWR];
      end
      if (oc_rise) begin
        pp_nxt = 1'b0;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pp_q <= 1'b1;
      end else begin
        pp_q <= pp_nxt;
      end
    end
  end else begin : g_pwr_fixed
    assign pp_nxt = 1'b1;
    assign pp_q   = 1'b1;
  end

  // ---------------- next state ----------------
  always_comb begin
    oc_rise = oc_active & ~oca_q;
    oc_chg  = oc_active ^ oca_q;
    disc    = ccs_q & ~dev_connected;
    ccs_nxt = pp_nxt & dev_connected;

    // bus reset request: cleared only by the sequencer
    pr_nxt = pr_q;
    if (pr_q && rst_done) begin
      pr_nxt = 1'b0;
    end
    if (wr_en && wr_data[B_RST]) begin
      pr_nxt = 1'b1;
    end
    pr_nxt  = pr_nxt & pp_nxt;
    pr_rise = pr_nxt & ~pr_q;

    // enable: software may only clear
    ped_nxt = ped_q;
    if (wr_en && !wr_data[B_ENA]) begin
      ped_nxt = 1'b0;
    end
    if (port_error || disc || pr_rise) begin
      ped_nxt = 1'b0;
    end
    if (pr_q && rst_done && hs_detected && dev_connected) begin
      ped_nxt = 1'b1;
    end
    ped_nxt = ped_nxt & pp_nxt;

    // force resume
    fpr_nxt = fpr_q;
    if (wr_en) begin
      fpr_nxt = wr_data[B_FPR];
    end
    if (resume_det && sus_q) begin
      fpr_nxt = 1'b1;
    end
    fpr_nxt  = fpr_nxt & ped_nxt & pp_nxt;
    fpr_fall = fpr_q & ~fpr_nxt;

    // suspend
    sus_nxt = sus_q;
    if (wr_en && wr_data[B_SUS] && ped_q) begin
      sus_nxt = 1'b1;
    end
    if (fpr_fall || pr_rise) begin
      sus_nxt = 1'b0;
    end
    sus_nxt = sus_nxt & ped_nxt & pp_nxt;

    // wake enables and indicator
    wake_nxt = wake_q;
    ind_nxt  = ind_q;
    if (wr_en) begin
      wake_nxt = wr_data[B_WAKE +: WAKE_W];
      ind_nxt  = wr_data[B_IND +: IND_W];
    end
    if (!pp_nxt) begin
      wake_nxt = '0;
      ind_nxt  = '0;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccs_q  <= 1'b0;
      oca_q  <= 1'b0;
      pr_q   <= 1'b0;
      ped_q  <= 1'b0;
      sus_q  <= 1'b0;
      fpr_q  <= 1'b0;
      wake_q <= '0;
      ind_q  <= '0;
    end else begin
      ccs_q  <= ccs_nxt;
      oca_q  <= oc_active;
      pr_q   <= pr_nxt;
      ped_q  <= ped_nxt;
      sus_q  <= sus_nxt;
      fpr_q  <= fpr_nxt;
      wake_q <= wake_nxt;
      ind_q  <= ind_nxt;
    end
  end

  // ---------------- sticky change flags ----------------
  always_comb begin
    flag_set[FLG_CONN]  = dev_connected ^ ccs_q;
    flag_clr[FLG_CONN]  = wr_en & wr_data[B_CSC];
    flag_keep[FLG_CONN] = pp_nxt;
    flag_set[FLG_ENA]   = port_error & ped_q;
    flag_clr[FLG_ENA]   = wr_en & wr_data[B_ENC];
    flag_keep[FLG_ENA]  = pp_nxt;
    flag_set[FLG_OVC]   = oc_chg;
    flag_clr[FLG_OVC]   = wr_en & wr_data[B_OCC];
    flag_keep[FLG_OVC]  = 1'b1;
  end

  for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
    hs_port_evflag i_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set[f]),
      .clr_i  (flag_clr[f]),
      .keep_i (flag_keep[f]),
      .flag_o (flag_q[f])
    );
  end

  hs_port_owner i_owner (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_flag (cfg_flag),
    .wr_en    (wr_en),
    .wr_bit   (wr_data[B_OWN]),
    .own_o    (own)
  );

  hs_port_testsel #(
    .CODE_W  (TEST_W),
    .N_MODES (N_TEST_MODES)
  ) i_test (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_code (wr_data[B_TEST +: TEST_W]),
    .code_o  (test_code),
    .sel_o   (test_sel_o)
  );

  // ---------------- read word and outputs ----------------
  always_comb begin
    rd_data                    = '0;
    rd_data[B_WAKE +: WAKE_W]  = wake_q;
    rd_data[B_TEST +: TEST_W]  = test_code;
    rd_data[B_IND +: IND_W]    = ind_q;
    rd_data[B_OWN]             = own;
    rd_data[B_PWR]             = pp_q;
    rd_data[B_LS +: 2]         = pp_q ? line_state : 2'b00;
    rd_data[B_RST]             = pr_q;
    rd_data[B_SUS]             = sus_q;
    rd_data[B_FPR]             = fpr_q;
    rd_data[B_OCC]             = flag_q[FLG_OVC];
    rd_data[B_OCA]             = oca_q;
    rd_data[B_ENC]             = flag_q[FLG_ENA];
    rd_data[B_ENA]             = ped_q;
    rd_data[B_CSC]             = flag_q[FLG_CONN];
    rd_data[B_CCS]             = ccs_q;
  end

  assign port_reset_o = pr_q;
  assign suspend_o    = sus_q;
  assign resume_o     = fpr_q;
  assign lowspeed_o   = pp_q & ccs_q & ~ped_q & (line_state == 2'b01);
endmodule

// File: rtl/hs_port_csr_chk.sv
module hs_port_csr_chk
  import hs_port_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [WORD_W-1:0] rd_data,
  input logic              cfg_flag,
  input logic              dev_connected,
  input logic              oc_active,
  input logic              rst_done,
  input logic              hs_detected
);
  // R2
  a_r2_conn_change_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[B_PWR] && !wr_en && !oc_active && (dev_connected != rd_data[B_CCS]))
      |=> rd_data[B_CSC]);

  // R3
  a_r3_oca_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_data[B_OCA] == $past(oc_active)));

  // R4
  a_r4_enable_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[B_ENA]) |-> $past(rst_done && hs_detected));

  // R6
  a_r6_suspend_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[B_SUS] |-> rd_data[B_ENA]);

  // R8
  a_r8_owner_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_flag |=> rd_data[B_OWN]);

  a_r8_owner_cfg_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_flag) |=> !rd_data[B_OWN]);

  // R10
  a_r10_power_gating: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[B_PWR] |-> ((rd_data & PWR_GATED_MASK) == '0));

  // R11
  a_r11_test_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[B_TEST +: TEST_W] <= TEST_W'(N_TEST_MODES));

  // R13
  a_r13_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RSVD_MASK) == '0);
endmodule

bind hs_port_csr hs_port_csr_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .rd_data       (rd_data),
  .cfg_flag      (cfg_flag),
  .dev_connected (dev_connected),
  .oc_active     (oc_active),
  .rst_done      (rst_done),
  .hs_detected   (hs_detected)
);

// File: tb/test_hs_port_csr.sv
module test_hs_port_csr;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        cfg_flag;
  logic        dev_connected;
  logic        oc_active;
  logic [1:0]  line_state;
  logic        port_error;
  logic        resume_det;
  logic        rst_done;
  logic        hs_detected;
  logic        port_reset_o;
  logic        suspend_o;
  logic        resume_o;
  logic [4:0]  test_sel_o;
  logic        lowspeed_o;

  int n_checks;
  int n_fail;
  bit done;

  hs_port_csr i_hs_port_csr (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .cfg_flag      (cfg_flag),
    .dev_connected (dev_connected),
    .oc_active     (oc_active),
    .line_state    (line_state),
    .port_error    (port_error),
    .resume_det    (resume_det),
    .rst_done      (rst_done),
    .hs_detected   (hs_detected),
    .port_reset_o  (port_reset_o),
    .suspend_o     (suspend_o),
    .resume_o      (resume_o),
    .test_sel_o    (test_sel_o),
    .lowspeed_o    (lowspeed_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // one edge, then sample 1 time unit later
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic reg_write(input logic [31:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    tick();
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic t_reset();
    check("R1 reset word", rd_data, 32'h0000_3000);
    check("R1 reset request idle", {31'd0, port_reset_o}, 32'd0);
    check("R11 reset test select", {27'd0, test_sel_o}, 32'd0);
  endtask

  task automatic t_owner();
    cfg_flag = 1'b1;
    tick();
    check("R8 owner cleared on cfg rise", {31'd0, rd_data[13]}, 32'd0);
    reg_write(32'h0000_3000);
    check("R8 owner writable when configured", {31'd0, rd_data[13]}, 32'd1);
    cfg_flag = 1'b0;
    reg_write(32'h0000_1000);
    check("R8 owner held while unconfigured", {31'd0, rd_data[13]}, 32'd1);
    cfg_flag = 1'b1;
    tick();
    check("R8 owner cleared again", {31'd0, rd_data[13]}, 32'd0);
  endtask

  task automatic t_connect();
    dev_connected = 1'b1;
    tick();
    check("R2 connect status/change", {30'd0, rd_data[1:0]}, 32'd3);
    dev_connected = 1'b0;
    tick();
    check("R2 disconnect keeps change", {30'd0, rd_data[1:0]}, 32'd2);
    dev_connected = 1'b1;
    tick();
    reg_write(32'h0000_1002);
    check("R2 write one clears change", {30'd0, rd_data[1:0]}, 32'd1);
    dev_connected = 1'b0;
    reg_write(32'h0000_1002);
    check("R14 set wins over clear", {30'd0, rd_data[1:0]}, 32'd2);
    dev_connected = 1'b1;
    tick();
    reg_write(32'h0000_1002);
    check("R2 cleared after reconnect", {30'd0, rd_data[1:0]}, 32'd1);
  endtask

  task automatic do_bus_reset();
    reg_write(32'h0000_1100);
    hs_detected = 1'b1;
    rst_done    = 1'b1;
    tick();
    rst_done    = 1'b0;
  endtask

  task automatic t_enable();
    reg_write(32'h0000_1004);
    check("R4 write one to enable ignored", {31'd0, rd_data[2]}, 32'd0);
    reg_write(32'h0000_1100);
    check("R5 reset set", {30'd0, port_reset_o, rd_data[8]}, 32'd3);
    reg_write(32'h0000_1000);
    check("R5 write zero keeps reset", {31'd0, rd_data[8]}, 32'd1);
    hs_detected = 1'b1;
    rst_done    = 1'b1;
    tick();
    rst_done    = 1'b0;
    check("R5 reset done clears, R4 enables", {29'd0, rd_data[8], port_reset_o, rd_data[2]}, 32'd1);
    port_error = 1'b1;
    tick();
    port_error = 1'b0;
    check("R4 error disables and flags", {28'd0, rd_data[3:2], 2'd0}, 32'h8);
    reg_write(32'h0000_1008);
    check("R4 enable change cleared", {31'd0, rd_data[3]}, 32'd0);
  endtask

  task automatic t_suspend();
    do_bus_reset();
    check("R4 enabled again", {31'd0, rd_data[2]}, 32'd1);
    reg_write(32'h0000_1084);
    check("R6 suspend set", {30'd0, suspend_o, rd_data[7]}, 32'd3);
    resume_det = 1'b1;
    tick();
    resume_det = 1'b0;
    check("R7 resume detect sets force resume", {30'd0, resume_o, rd_data[6]}, 32'd3);
    reg_write(32'h0000_1004);
    check("R7 resume end clears both", {29'd0, rd_data[7:6], rd_data[2]}, 32'd1);
    reg_write(32'h0000_1000);
    reg_write(32'h0000_1080);
    check("R6 suspend ignored when disabled", {31'd0, rd_data[7]}, 32'd0);
  endtask

  task automatic t_test();
    reg_write(32'h0003_1000);
    check("R11 code 3 accepted", {28'd0, rd_data[19:16]}, 32'd3);
    check("R11 one-hot for 3", {27'd0, test_sel_o}, 32'h4);
    reg_write(32'h0009_1000);
    check("R11 reserved code ignored", {28'd0, rd_data[19:16]}, 32'd3);
    reg_write(32'h0005_1000);
    check("R11 one-hot for 5", {27'd0, test_sel_o}, 32'h10);
    reg_write(32'h0000_1000);
    check("R11 normal mode", {27'd0, test_sel_o}, 32'd0);
  endtask

  task automatic t_line();
    line_state = 2'b01;
    tick();
    check("R12 line status K", {30'd0, rd_data[11:10]}, 32'd1);
    check("R12 low-speed hint", {31'd0, lowspeed_o}, 32'd1);
    line_state = 2'b10;
    tick();
    check("R12 J gives no hint", {29'd0, rd_data[11:10], lowspeed_o}, 32'h4);
  endtask

  task automatic t_reserved();
    reg_write(32'hFF80_1200);
    check("R13 reserved bits zero", rd_data & 32'hFF80_0200, 32'd0);
  endtask

  task automatic t_power();
    reg_write(32'h0070_9000);
    check("R10 wake and indicator held", {27'd0, rd_data[22:20], rd_data[15:14]}, 32'h1E);
    reg_write(32'h0070_8000);
    check("R10 gated fields zero", rd_data & 32'h0070_DDCF, 32'd0);
    reg_write(32'h0000_1000);
    check("R10 power back, connect seen", {29'd0, rd_data[12], rd_data[1:0]}, 32'h7);
    check("R10 wake not restored", {29'd0, rd_data[22:20]}, 32'd0);
    reg_write(32'h0000_1002);
  endtask

  task automatic t_overcurrent();
    oc_active = 1'b1;
    tick();
    check("R3 overcurrent active and change", {30'd0, rd_data[5:4]}, 32'd3);
    check("R9 overcurrent removes power", {31'd0, rd_data[12]}, 32'd0);
    oc_active = 1'b0;
    tick();
    check("R3 overcurrent end flags change", {30'd0, rd_data[5:4]}, 32'd2);
    reg_write(32'h0000_1020);
    check("R3 change cleared, R9 power written", {30'd0, rd_data[12], rd_data[5]}, 32'd2);
  endtask

  initial begin
    done = 1'b0;
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks      = 0;
    n_fail        = 0;
    rst_n         = 1'b0;
    wr_en         = 1'b0;
    wr_data       = '0;
    cfg_flag      = 1'b0;
    dev_connected = 1'b0;
    oc_active     = 1'b0;
    line_state    = 2'b00;
    port_error    = 1'b0;
    resume_det    = 1'b0;
    rst_done      = 1'b0;
    hs_detected   = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    tick();
    t_reset();
    t_owner();
    t_connect();
    t_enable();
    t_suspend();
    t_test();
    t_line();
    t_reserved();
    t_power();
    t_overcurrent();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule